// File: doc/BRIEF.md
# Queue Buffer Space Allocator

This block keeps the books for one external buffer memory that several queues share. The memory is cut into equal slices, and queues take or give back space one slice at a time. Every queue has a floor of slices it can always obtain. Above that floor a queue may take any slice nobody holds. When the memory is full and a queue below its floor asks for space, the block takes one slice back from the queue that is most over its own floor and hands that slice to the requester.

A request is a single-cycle pulse on `req_valid` with an operation and a queue index. The block never back-pressures: it accepts every valid request, at most one per cycle. An allocate request gets a response code on the next cycle. A release request produces either a silent decrement or an error pulse on the next cycle. The per-queue used space is reported in dwords. Slices fill without gaps, so a queue's dword count is always its slice count times the slice size. Address generation and the data path to the memory are outside this block.

Top module: `qbuf_space_alloc`

## Requirements
- R1: During and straight after reset every per-queue dword count is zero, the response code is 00 and no reclaim or error pulse is present, so all slices are free.
- R2: A request is taken in the cycle `req_valid` is high (`req_op` 0 = allocate, 1 = release). An allocate gets a non-zero `rsp_code` in the following cycle only. Any cycle without an allocate request is followed by `rsp_code` 00.
- R3: An allocate while at least one slice is free is granted (code 01) and adds one slice to the requesting queue, whether or not that queue is already above its floor.
- R4: An allocate while no slice is free, from a queue at or above its floor, is denied (code 11) and leaves every queue's count unchanged.
- R5: An allocate while no slice is free, from a queue below its floor, returns code 10 and raises `reclaim_pulse` for one cycle. `reclaim_qid` names the victim, which is the queue with the largest excess over its floor; the lowest index wins a tie. The victim loses one slice and the requester gains one.
- R6: A release from a queue holding at least one slice removes one slice from that queue only.
- R7: A release from a queue holding zero slices changes no count and raises `rel_err` for one cycle.
- R8: The sum of slices in use never exceeds the total slice count.
- R9: Each field of `used_dwords` (queue i at bits i*DWW upward) equals that queue's slice count times the slice size in dwords.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 1 | 0 allocate, 1 release |
| req_qid | input | QW | Requesting queue index |
| rsp_code | output | 2 | 00 none, 01 grant, 10 grant with reclaim, 11 deny |
| reclaim_pulse | output | 1 | One-cycle pulse when a slice was taken back |
| reclaim_qid | output | QW | Victim queue for the reclaim |
| rel_err | output | 1 | One-cycle pulse for a release from an empty queue |
| used_dwords | output | NUM_Q*DWW | Packed per-queue used dword counts |

## Verification
The hardest condition to reach is a reclaim with a tie. The memory must be full, the requester must sit below its floor, and two other queues must hold equal excess, so that the lowest-index rule decides the victim. The stimulus first fills the whole memory from one queue and then pulls a queue below its floor to force reclaims. It then trims that queue with releases and lets a second queue borrow the freed slices until both hold the same excess. A third queue, still under its floor, requests next, which drives the tie and then the step right after it. A seeded random phase follows, with every outcome predicted by a scoreboard model.

// File: rtl/qsa_pkg.sv
package qsa_pkg;
  typedef enum logic [1:0] {
    RSP_NONE    = 2'b00,
    RSP_GRANT   = 2'b01,
    RSP_RECLAIM = 2'b10,
    RSP_DENY    = 2'b11
  } rsp_e;

  localparam logic OP_ALLOC   = 1'b0;
  localparam logic OP_RELEASE = 1'b1;
endpackage

// File: rtl/qsa_victim_sel.sv
// Picks the queue holding the most slices above its floor; lowest index wins ties.
module qsa_victim_sel #(
  parameter int NUM_Q = 4,
  parameter int CW    = 5,
  parameter int QW    = 2,
  parameter logic [NUM_Q*8-1:0] FLOORS = '0
) (
  input  logic [NUM_Q*CW-1:0] cnt_flat,
  output logic [QW-1:0]       victim
);
  logic [CW-1:0] cnt_i, floor_i, excess_i, best_amt;

  always_comb begin
    best_amt = '0;
    victim   = '0;
    cnt_i    = '0;
    floor_i  = '0;
    excess_i = '0;
    for (int i = 0; i < NUM_Q; i++) begin
      cnt_i    = cnt_flat[i*CW +: CW];
      floor_i  = CW'(FLOORS[i*8 +: 8]);
      excess_i = (cnt_i > floor_i) ? cnt_i - floor_i : '0;
      if (excess_i > best_amt) begin
        best_amt = excess_i;
        victim   = QW'(i);
      end
    end
  end
endmodule

// File: rtl/qsa_decide.sv
// Combinational decision for the request presented this cycle.
module qsa_decide
  import qsa_pkg::*;
#(
  parameter int NUM_Q        = 4,
  parameter int TOTAL_SLICES = 16,
  parameter int CW           = 5,
  parameter int QW           = 2,
  parameter logic [NUM_Q*8-1:0] FLOORS = '0
) (
  input  logic [NUM_Q*CW-1:0] cnt_flat,
  input  logic                req_valid,
  input  logic                req_op,
  input  logic [QW-1:0]       req_qid,
  output logic                inc_en,
  output logic [QW-1:0]       inc_q,
  output logic                dec_en,
  output logic [QW-1:0]       dec_q,
  output rsp_e                code_nxt,
  output logic                err_nxt,
  output logic [QW-1:0]       victim
);
  localparam int SW = CW + QW;

  logic [SW-1:0] in_use;
  logic [CW-1:0] own_cnt, own_floor;
  logic          any_free;

  qsa_victim_sel #(.NUM_Q(NUM_Q), .CW(CW), .QW(QW), .FLOORS(FLOORS)) u_vsel (
    .cnt_flat (cnt_flat),
    .victim   (victim)
  );

  always_comb begin
    in_use = '0;
    for (int i = 0; i < NUM_Q; i++) in_use = in_use + SW'(cnt_flat[i*CW +: CW]);
  end

  assign any_free  = in_use < SW'(TOTAL_SLICES);
  assign own_cnt   = cnt_flat[req_qid*CW +: CW];
  assign own_floor = CW'(FLOORS[req_qid*8 +: 8]);

  always_comb begin
    inc_en   = 1'b0;
    dec_en   = 1'b0;
    inc_q    = req_qid;
    dec_q    = req_qid;
    code_nxt = RSP_NONE;
    err_nxt  = 1'b0;
    if (req_valid) begin
      if (req_op == OP_ALLOC) begin
        if (any_free) begin
          inc_en   = 1'b1;
          code_nxt = RSP_GRANT;
        end else if (own_cnt < own_floor) begin
          inc_en   = 1'b1;
          dec_en   = 1'b1;
          dec_q    = victim;
          code_nxt = RSP_RECLAIM;
        end else begin
          code_nxt = RSP_DENY;
        end
      end else if (own_cnt == '0) begin
        err_nxt = 1'b1;
      end else begin
        dec_en = 1'b1;
      end
    end
  end
endmodule

// File: rtl/qsa_slice_bank.sv
// One slice counter per queue plus its dword view.
module qsa_slice_bank #(
  parameter int NUM_Q        = 4,
  parameter int CW           = 5,
  parameter int QW           = 2,
  parameter int DWW          = 11,
  parameter int SLICE_DWORDS = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 inc_en,
  input  logic [QW-1:0]        inc_q,
  input  logic                 dec_en,
  input  logic [QW-1:0]        dec_q,
  output logic [NUM_Q*CW-1:0]  cnt_flat,
  output logic [NUM_Q*DWW-1:0] dw_flat
);
  for (genvar g = 0; g < NUM_Q; g++) begin : g_q
    logic [CW-1:0] cnt;
    logic          up, down;

    assign up   = inc_en && (inc_q == QW'(g));
    assign down = dec_en && (dec_q == QW'(g));

    always_ff @(posedge clk) begin
      if (!rst_n)          cnt <= '0;
      else if (up && !down) cnt <= cnt + 1'b1;
      else if (down && !up) cnt <= cnt - 1'b1;
    end

    assign cnt_flat[g*CW +: CW]   = cnt;
    assign dw_flat[g*DWW +: DWW]  = DWW'(cnt) * DWW'(SLICE_DWORDS);
  end
endmodule

// File: rtl/qbuf_space_alloc.sv
module qbuf_space_alloc
  import qsa_pkg::*;
#(
  parameter int NUM_Q        = 4,
  parameter int TOTAL_SLICES = 16,
  parameter int SLICE_DWORDS = 64,
  // floor per queue, 8 bits each, queue 0 in the low byte
  parameter logic [NUM_Q*8-1:0] FLOORS = 32'h01040302,
  localparam int QW  = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
  localparam int CW  = $clog2(TOTAL_SLICES + 1),
  localparam int DWW = CW + $clog2(SLICE_DWORDS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_op,
  input  logic [QW-1:0]        req_qid,
  output logic [1:0]           rsp_code,
  output logic                 reclaim_pulse,
  output logic [QW-1:0]        reclaim_qid,
  output logic                 rel_err,
  output logic [NUM_Q*DWW-1:0] used_dwords
);
  logic [NUM_Q*CW-1:0] cnt_flat;
  logic                inc_en, dec_en, err_nxt;
  logic [QW-1:0]       inc_q, dec_q, victim;
  rsp_e                code_nxt;

  qsa_decide #(
    .NUM_Q(NUM_Q), .TOTAL_SLICES(TOTAL_SLICES), .CW(CW), .QW(QW), .FLOORS(FLOORS)
  ) u_decide (
    .cnt_flat (cnt_flat),
    .req_valid(req_valid),
    .req_op   (req_op),
    .req_qid  (req_qid),
    .inc_en   (inc_en),
    .inc_q    (inc_q),
    .dec_en   (dec_en),
    .dec_q    (dec_q),
    .code_nxt (code_nxt),
    .err_nxt  (err_nxt),
    .victim   (victim)
  );

  qsa_slice_bank #(
    .NUM_Q(NUM_Q), .CW(CW), .QW(QW), .DWW(DWW), .SLICE_DWORDS(SLICE_DWORDS)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc_en  (inc_en),
    .inc_q   (inc_q),
    .dec_en  (dec_en),
    .dec_q   (dec_q),
    .cnt_flat(cnt_flat),
    .dw_flat (used_dwords)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_code      <= RSP_NONE;
      reclaim_pulse <= 1'b0;
      reclaim_qid   <= '0;
      rel_err       <= 1'b0;
    end else begin
      rsp_code      <= code_nxt;
      reclaim_pulse <= (code_nxt == RSP_RECLAIM);
      reclaim_qid   <= victim;
      rel_err       <= err_nxt;
    end
  end
endmodule

// File: rtl/qbuf_space_alloc_chk.sv
module qbuf_space_alloc_chk #(
  parameter int NUM_Q        = 4,
  parameter int TOTAL_SLICES = 16,
  parameter int SLICE_DWORDS = 64,
  parameter int QW           = 2,
  parameter int DWW          = 11
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_op,
  input logic [1:0]           rsp_code,
  input logic                 reclaim_pulse,
  input logic                 rel_err,
  input logic [NUM_Q*DWW-1:0] used_dwords
);
  localparam int TW = DWW + QW + 1;
  logic [TW-1:0] total_dw;

  always_comb begin
    total_dw = '0;
    for (int i = 0; i < NUM_Q; i++) total_dw = total_dw + TW'(used_dwords[i*DWW +: DWW]);
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    total_dw <= TW'(TOTAL_SLICES * SLICE_DWORDS));

  assert_alloc_answered_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_op) |=> (rsp_code != 2'b00));

  assert_quiet_without_alloc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_op) |=> (rsp_code == 2'b00));

  assert_grant_adds_slice_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_code == 2'b01) |-> (total_dw == $past(total_dw) + TW'(SLICE_DWORDS)));

  assert_deny_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_code == 2'b11) |-> $stable(used_dwords));

  assert_reclaim_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reclaim_pulse |-> ($stable(total_dw) && !$stable(used_dwords)));

  assert_err_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rel_err |-> $stable(used_dwords));
endmodule

bind qbuf_space_alloc qbuf_space_alloc_chk #(
  .NUM_Q(NUM_Q), .TOTAL_SLICES(TOTAL_SLICES), .SLICE_DWORDS(SLICE_DWORDS),
  .QW(QW), .DWW(DWW)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_op       (req_op),
  .rsp_code     (rsp_code),
  .reclaim_pulse(reclaim_pulse),
  .rel_err      (rel_err),
  .used_dwords  (used_dwords)
);

// File: tb/qbuf_space_alloc_test.sv
module qbuf_space_alloc_test;
  localparam int CLK_PERIOD = 10;
  localparam int NQ  = 4;
  localparam int TOT = 16;
  localparam int SD  = 64;
  localparam logic [NQ*8-1:0] FL = 32'h01040302;
  localparam int QW  = 2;
  localparam int DWW = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_op = 1'b0;
  logic [QW-1:0] req_qid = '0;
  logic [1:0] rsp_code;
  logic reclaim_pulse, rel_err;
  logic [QW-1:0] reclaim_qid;
  logic [NQ*DWW-1:0] used_dwords;

  always #(CLK_PERIOD/2) clk = ~clk;

  qbuf_space_alloc #(.NUM_Q(NQ), .TOTAL_SLICES(TOT), .SLICE_DWORDS(SD), .FLOORS(FL)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_qid(req_qid),
    .rsp_code(rsp_code), .reclaim_pulse(reclaim_pulse), .reclaim_qid(reclaim_qid),
    .rel_err(rel_err), .used_dwords(used_dwords)
  );

  typedef struct {
    int          due;
    logic [1:0]  code;
    bit          rc;
    int          vic;
    bit          err;
    logic [31:0] cnts;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   model[NQ];
  int   cyc = 0;
  int   checks = 0, errors = 0;
  bit   done = 1'b0;
  logic [31:0] lfsr = 32'h1234_5678;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int floor_of(int q);
    return int'(FL[q*8 +: 8]);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, expv);
    end
  endtask

  // driver: predicts the outcome, pushes it, then waits one cycle
  task automatic step(input bit v, input bit op, input int q);
    exp_t e;
    int sum, best, bq;
    req_valid = v; req_op = op; req_qid = QW'(q);
    e.due = cyc + 1; e.code = 2'b00; e.rc = 0; e.vic = 0; e.err = 0; e.tag = "R2";
    if (v && !op) begin
      sum = 0;
      for (int i = 0; i < NQ; i++) sum += model[i];
      if (sum < TOT) begin
        model[q]++; e.code = 2'b01; e.tag = "R3";
      end else if (model[q] < floor_of(q)) begin
        best = 0; bq = 0;
        for (int i = 0; i < NQ; i++)
          if (model[i] - floor_of(i) > best) begin best = model[i] - floor_of(i); bq = i; end
        model[bq]--; model[q]++;
        e.code = 2'b10; e.rc = 1; e.vic = bq; e.tag = "R5";
      end else begin
        e.code = 2'b11; e.tag = "R4";
      end
    end else if (v) begin
      if (model[q] == 0) begin e.err = 1; e.tag = "R7"; end
      else begin model[q]--; e.tag = "R6"; end
    end
    for (int i = 0; i < NQ; i++) e.cnts[i*8 +: 8] = 8'(model[i]);
    exp_q.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor: compares results in the cycle they are due
  always @(negedge clk) begin : mon
    exp_t e;
    int tot;
    if (rst_n) begin
      tot = 0;
      for (int i = 0; i < NQ; i++) tot += int'(used_dwords[i*DWW +: DWW]);
      chk(tot <= TOT*SD, "R8 total in use", tot, TOT*SD);
      while (exp_q.size() > 0 && exp_q[0].due == cyc) begin
        e = exp_q.pop_front();
        chk(rsp_code == e.code, {e.tag, " rsp_code"}, int'(rsp_code), int'(e.code));
        chk(reclaim_pulse == e.rc, {e.tag, " R5 reclaim_pulse"}, int'(reclaim_pulse), int'(e.rc));
        if (e.rc) chk(int'(reclaim_qid) == e.vic, "R5 victim", int'(reclaim_qid), e.vic);
        chk(rel_err == e.err, {e.tag, " R7 rel_err"}, int'(rel_err), int'(e.err));
        for (int i = 0; i < NQ; i++)
          chk(int'(used_dwords[i*DWW +: DWW]) == int'(e.cnts[i*8 +: 8]) * SD,
              {e.tag, " R9 used_dwords"}, int'(used_dwords[i*DWW +: DWW]),
              int'(e.cnts[i*8 +: 8]) * SD);
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 50000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NQ; i++) model[i] = 0;
    repeat (3) @(negedge clk);
    // R1: state under reset
    chk(used_dwords == '0, "R1 dwords zero", int'(used_dwords[DWW-1:0]), 0);
    chk(rsp_code == 2'b00 && !reclaim_pulse && !rel_err, "R1 outputs idle", int'(rsp_code), 0);
    rst_n = 1'b1;
    step(0, 0, 0);                                   // R2 idle cycle
    step(1, 1, 0);                                   // R7 release from empty
    for (int k = 0; k < 16; k++) step(1, 0, 0);      // R3 q0 fills everything
    step(1, 0, 0);                                   // R4 full, q0 above floor
    step(1, 0, 3);                                   // R5 reclaim from q0
    step(1, 0, 3);                                   // R4 q3 at its floor
    step(1, 0, 1);                                   // R5 again
    for (int k = 0; k < 7; k++) step(1, 1, 0);       // R6 trims q0 to excess 5
    for (int k = 0; k < 7; k++) step(1, 0, 1);       // R3 q1 borrows to excess 5
    step(1, 0, 2);                                   // R5 tie, lowest index q0
    step(1, 0, 2);                                   // R5 q1 now largest
    step(1, 0, 2);                                   // R5 tie again at 4
    step(1, 1, 3); step(1, 1, 3); step(1, 1, 3);     // R6 then R7
    for (int k = 0; k < 300; k++) begin
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      step(lfsr[0] | lfsr[1], lfsr[2] & lfsr[3], int'(lfsr[5:4]));
    end
    step(0, 0, 0);
    step(0, 0, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule